// File: doc/BRIEF.md
# Temperature Result Conditioner

This block sits between the acquisition side of a thermal-monitoring bridge and the host register file. Each time a fresh 16-bit temperature word arrives for one of the sources, the block stores a filtered copy of it for that source. Every stored word is presented to the host continuously, after two optional steps: conversion to an integer-only view and addition of a programmable signed offset. Temperatures are 16-bit two's complement in 1/64 °C steps, so +1 °C sits at bit 6. Any word in the range 8000h..81FFh is a status code, not a temperature, and passes through every stage unchanged.

A companion scanner answers a host request for the hottest source. One cycle after the request it latches the largest presented value among the enabled sources that hold a real temperature, together with that source's index. When no candidate exists it reports the code 8103h in both places instead.

Top module: `tcond_top`

## Requirements
- R1: After reset every source presents 8102h (no sample yet), `max_word` and `max_src` both read 8103h, and `offset_view` reads 0000h.
- R2: A sample whose value lies in 8000h..81FFh (bits 15:9 equal 1000000b) is stored and presented exactly as received, whatever the shift count, format and offset.
- R3: For a valid sample, the stored value becomes the raw word when `avg_shift` is 0, or when the source held no valid value (after reset or after a status code). Otherwise it becomes old + floor((raw − old) / 2^avg_shift), computed exactly, with rounding toward negative infinity.
- R4: With `alt_fmt` = 1, a valid stored value is presented arithmetically shifted right by 6, so the upper byte is sign fill and the lower byte is whole degrees.
- R5: A valid presented value is the stored value, converted to the selected format, plus the offset in that same format, wrapping modulo 2^16. Averaging happens first, then format conversion, then the offset.
- R6: An offset written while `alt_fmt` = 1 is taken as whole degrees and is held internally multiplied by 64. `offset_view` always shows the offset in the current format (for example 17C0h in full format, 005Fh in integer format).
- R7: One cycle after `max_req`, `max_word` holds the largest presented value by signed comparison among sources that are enabled in `src_en` and hold a valid temperature. `max_src` holds that source's index (0..NSRC−1), with the lowest index winning a tie. Without `max_req`, both outputs hold their values.
- R8: When a request finds no enabled source holding a valid temperature, both `max_word` and `max_src` become 8103h.
- R9: Until the first `max_req` after reset, `max_src` reads 8103h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A new raw word is present this cycle |
| smp_src | input | IDXW (3) | Source index of the new word |
| smp_word | input | 16 | Raw temperature word or status code |
| avg_shift | input | 8 | Averaging shift count, 0 disables averaging |
| alt_fmt | input | 1 | 1 selects the integer-degree presentation |
| off_wr | input | 1 | Write strobe for the offset |
| off_data | input | 16 | Offset value, expressed in the current format |
| src_en | input | NSRC (8) | Sources taking part in the maximum search |
| max_req | input | 1 | Request a new maximum scan |
| result_flat | output | NSRC*16 (128) | Presented word of each source, source i at bits 16i+15:16i |
| offset_view | output | 16 | Offset shown in the current format |
| max_word | output | 16 | Latched maximum value or 8103h |
| max_src | output | 16 | Latched index of the maximum or 8103h |

## Verification
The averaging path gets a run of valid samples on one source with shift counts 0, 1 and 2. The run includes differences of +1 and −1 at shift 1, which separates floor rounding from truncation toward zero. Status codes go to sources that hold valid data, and a valid word then follows one of them; this shows that the code bypasses every stage and that the next valid word is loaded directly instead of being averaged. Offsets are written and read back in both formats to expose the internal scaling. The maximum search runs over enable masks that pick the largest value, skip a status code, force a tie, and leave no candidate at all.

// File: rtl/tcond_pkg.sv
// Package: shared constants and helpers for the temperature conditioner.
// Assumes 16-bit words with 6 fractional bits.
package tcond_pkg;
    localparam int TW   = 16;
    localparam int FRAC = 6;
    localparam logic [TW-1:0] CODE_PENDING = 16'h8102;
    localparam logic [TW-1:0] CODE_NOMAX   = 16'h8103;

    // True when the word lies in the status-code range 8000h..81FFh.
    function automatic logic is_code(input logic [TW-1:0] w);
        return (w[TW-1:9] == 7'b1000000);
    endfunction
endpackage

// File: rtl/tcond_avg_lane.sv
// Module: storage and exponential averaging for one source.
// It accepts the sample only when smp_src matches LANE. A status code is
// stored as is and un-primes the lane. The first valid word after that is
// loaded directly. Later words move the stored value by
// (raw-old) >>> shift, which rounds toward negative infinity.
module tcond_avg_lane
    import tcond_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int LANE = 0,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [IDXW-1:0] smp_src,
    input  logic [TW-1:0]   smp_word,
    input  logic [7:0]      avg_shift,
    output logic [TW-1:0]   store_o
);
    localparam logic [IDXW-1:0] MY_IDX = IDXW'(LANE);

    logic        primed;
    logic        hit;
    logic signed [31:0] raw_x, old_x, diff_x, step_x;
    logic [TW-1:0] blended;

    // Purpose: exact 32-bit blend of the raw word into the stored one.
    always_comb begin
        hit     = smp_valid && (smp_src == MY_IDX);
        raw_x   = {{(32-TW){smp_word[TW-1]}}, smp_word};
        old_x   = {{(32-TW){store_o[TW-1]}}, store_o};
        diff_x  = raw_x - old_x;
        step_x  = diff_x >>> avg_shift;
        blended = store_o + step_x[TW-1:0];
    end

    // Purpose: update the stored value and the primed flag of this lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_o <= CODE_PENDING;
            primed  <= 1'b0;
        end else if (hit) begin
            if (is_code(smp_word)) begin
                store_o <= smp_word;
                primed  <= 1'b0;
            end else if (!primed || avg_shift == 8'd0) begin
                store_o <= smp_word;
                primed  <= 1'b1;
            end else begin
                store_o <= blended;
                primed  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tcond_present.sv
// Module: combinational presentation of one stored word.
// It converts a valid word to the selected format and then adds the offset
// in that same format. A status code is passed on unchanged. The offset
// arrives in full (1/64 degree) format.
module tcond_present
    import tcond_pkg::*;
(
    input  logic [TW-1:0] word_i,
    input  logic          alt_fmt,
    input  logic [TW-1:0] off_full,
    output logic [TW-1:0] word_o
);
    logic [TW-1:0] w_int, o_int;

    // Purpose: format conversion, then offset addition, with code bypass.
    always_comb begin
        w_int = TW'($signed(word_i) >>> FRAC);
        o_int = TW'($signed(off_full) >>> FRAC);
        if (is_code(word_i))
            word_o = word_i;
        else if (alt_fmt)
            word_o = w_int + o_int;
        else
            word_o = word_i + off_full;
    end
endmodule

// File: rtl/tcond_max_scan.sv
// Module: searches for the maximum and latches the result on request.
// A source is a candidate when ok_i is set for it. The scan compares the
// presented words as signed numbers, and a strict compare in ascending
// order keeps the lowest index on a tie.
module tcond_max_scan
    import tcond_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [NSRC-1:0]    ok_i,
    input  logic [NSRC*TW-1:0] words_i,
    output logic [TW-1:0]      max_word,
    output logic [TW-1:0]      max_src
);
    logic            found;
    logic [TW-1:0]   best;
    logic [IDXW-1:0] best_idx;

    // Purpose: linear scan for the largest candidate.
    always_comb begin
        found    = 1'b0;
        best     = '0;
        best_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (ok_i[i] && (!found || $signed(words_i[i*TW +: TW]) > $signed(best))) begin
                found    = 1'b1;
                best     = words_i[i*TW +: TW];
                best_idx = IDXW'(i);
            end
        end
    end

    // Purpose: latch the scan result when the host asks for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_word <= CODE_NOMAX;
            max_src  <= CODE_NOMAX;
        end else if (req) begin
            if (found) begin
                max_word <= best;
                max_src  <= TW'(best_idx);
            end else begin
                max_word <= CODE_NOMAX;
                max_src  <= CODE_NOMAX;
            end
        end
    end
endmodule

// File: rtl/tcond_top.sv
// Module: top of the temperature conditioner.
// It holds one averaging lane and one presentation stage per source, the
// offset register (kept in full format and rescaled on every read) and the
// maximum scanner. It assumes the host never asks for the maximum in the
// same cycle as a sample it wants included in the scan.
module tcond_top
    import tcond_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [IDXW-1:0]    smp_src,
    input  logic [TW-1:0]      smp_word,
    input  logic [7:0]         avg_shift,
    input  logic               alt_fmt,
    input  logic               off_wr,
    input  logic [TW-1:0]      off_data,
    input  logic [NSRC-1:0]    src_en,
    input  logic               max_req,
    output logic [NSRC*TW-1:0] result_flat,
    output logic [TW-1:0]      offset_view,
    output logic [TW-1:0]      max_word,
    output logic [TW-1:0]      max_src
);
    logic [NSRC*TW-1:0] store_flat;
    logic [NSRC-1:0]    cand_ok;
    logic [TW-1:0]      off_full;

    // Purpose: hold the offset in full format, scaling integer-format writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_full <= '0;
        else if (off_wr)
            off_full <= alt_fmt ? {off_data[TW-FRAC-1:0], {FRAC{1'b0}}} : off_data;
    end

    // Purpose: show the offset in the format currently selected.
    always_comb offset_view = alt_fmt ? TW'($signed(off_full) >>> FRAC) : off_full;

    for (genvar g = 0; g < NSRC; g++) begin : g_lane
        tcond_avg_lane #(.NSRC(NSRC), .LANE(g), .IDXW(IDXW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp_src   (smp_src),
            .smp_word  (smp_word),
            .avg_shift (avg_shift),
            .store_o   (store_flat[g*TW +: TW])
        );

        tcond_present u_pres (
            .word_i   (store_flat[g*TW +: TW]),
            .alt_fmt  (alt_fmt),
            .off_full (off_full),
            .word_o   (result_flat[g*TW +: TW])
        );

        // Purpose: mark the enabled sources that hold a real temperature.
        always_comb cand_ok[g] = src_en[g] && !is_code(store_flat[g*TW +: TW]);
    end

    tcond_max_scan #(.NSRC(NSRC), .IDXW(IDXW)) u_max (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (max_req),
        .ok_i     (cand_ok),
        .words_i  (result_flat),
        .max_word (max_word),
        .max_src  (max_src)
    );
endmodule

// File: rtl/tcond_chk.sv
// Module: assertion checker for tcond_top, attached with bind.
// It watches the sample port, the stored and presented words, the internal
// full-format offset and the maximum outputs.
module tcond_chk
    import tcond_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_valid,
    input logic [IDXW-1:0]    smp_src,
    input logic [TW-1:0]      smp_word,
    input logic [7:0]         avg_shift,
    input logic               alt_fmt,
    input logic               off_wr,
    input logic [TW-1:0]      off_data,
    input logic               max_req,
    input logic [NSRC*TW-1:0] store_flat,
    input logic [NSRC*TW-1:0] result_flat,
    input logic [TW-1:0]      off_full,
    input logic [TW-1:0]      max_word,
    input logic [TW-1:0]      max_src
);
    logic [IDXW-1:0] last_src;
    logic [TW-1:0]   last_word;
    logic [TW-1:0]   last_off;

    // Purpose: remember the previous cycle's sample and offset inputs.
    always_ff @(posedge clk) begin
        last_src  <= smp_src;
        last_word <= smp_word;
        last_off  <= off_data;
    end

    p_code_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && is_code(smp_word) |=> store_flat[last_src*TW +: TW] == last_word);

    p_code_shown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && is_code(smp_word) |=> result_flat[last_src*TW +: TW] == last_word);

    p_direct_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && avg_shift == 8'd0 |=> store_flat[last_src*TW +: TW] == last_word);

    p_offset_scale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr && alt_fmt |=> off_full[FRAC-1:0] == '0 &&
                              off_full[TW-1:FRAC] == last_off[TW-FRAC-1:0]);

    p_max_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !max_req |=> $stable(max_word) && $stable(max_src));

    p_max_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        max_src != CODE_NOMAX |-> max_src < TW'(NSRC));

    p_no_max_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        max_src == CODE_NOMAX |-> max_word == CODE_NOMAX);
endmodule

bind tcond_top tcond_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_src     (smp_src),
    .smp_word    (smp_word),
    .avg_shift   (avg_shift),
    .alt_fmt     (alt_fmt),
    .off_wr      (off_wr),
    .off_data    (off_data),
    .max_req     (max_req),
    .store_flat  (store_flat),
    .result_flat (result_flat),
    .off_full    (off_full),
    .max_word    (max_word),
    .max_src     (max_src)
);

// File: tb/sim_tcond_top.sv
// Bench: walks a table of samples on the 50 MHz clock, then runs directed
// checks on reset, offsets and the maximum search.
module sim_tcond_top;
    localparam int NSRC = 8;
    localparam int IDXW = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic [IDXW-1:0]     smp_src = '0;
    logic [15:0]         smp_word = '0;
    logic [7:0]          avg_shift = '0;
    logic                alt_fmt = 1'b0;
    logic                off_wr = 1'b0;
    logic [15:0]         off_data = '0;
    logic [NSRC-1:0]     src_en = '0;
    logic                max_req = 1'b0;
    logic [NSRC*16-1:0]  result_flat;
    logic [15:0]         offset_view, max_word, max_src;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tcond_top #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_src(smp_src),
        .smp_word(smp_word), .avg_shift(avg_shift), .alt_fmt(alt_fmt),
        .off_wr(off_wr), .off_data(off_data), .src_en(src_en), .max_req(max_req),
        .result_flat(result_flat), .offset_view(offset_view),
        .max_word(max_word), .max_src(max_src)
    );

    // Fields: src[43:41] alt[40] shift[39:32] word[31:16] expected[15:0]
    localparam logic [43:0] VEC [12] = '{
        {3'd0, 1'b0, 8'd0, 16'hFFC0, 16'hFFC0},  // R3 first sample loaded
        {3'd0, 1'b0, 8'd2, 16'h0000, 16'hFFD0},  // R3 -64 + 64/4
        {3'd0, 1'b0, 8'd2, 16'h0000, 16'hFFDC},  // R3 -48 + 48/4
        {3'd0, 1'b0, 8'd1, 16'hFFC0, 16'hFFCE},  // R3 -36 + (-28)/2
        {3'd0, 1'b0, 8'd1, 16'hFFCF, 16'hFFCE},  // R3 +1 >>> 1 = 0
        {3'd0, 1'b0, 8'd1, 16'hFFCD, 16'hFFCD},  // R3 -1 >>> 1 = -1 (floor)
        {3'd1, 1'b0, 8'd3, 16'h8100, 16'h8100},  // R2 code stored
        {3'd1, 1'b0, 8'd3, 16'h0640, 16'h0640},  // R3 direct after code
        {3'd1, 1'b1, 8'd0, 16'hF700, 16'hFFDC},  // R4 -36 degrees
        {3'd2, 1'b1, 8'd0, 16'h17C0, 16'h005F},  // R4 +95 degrees
        {3'd2, 1'b1, 8'd0, 16'h8000, 16'h8000},  // R2 code in integer format
        {3'd3, 1'b0, 8'd5, 16'h1000, 16'h1000}   // R3 first valid on new source
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic put_sample(input logic [2:0] s, input logic [15:0] w);
        @(negedge clk);
        smp_src = s; smp_word = w; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic write_off(input logic [15:0] v);
        @(negedge clk);
        off_data = v; off_wr = 1'b1;
        @(negedge clk);
        off_wr = 1'b0;
    endtask

    task automatic ask_max(input logic [7:0] en);
        @(negedge clk);
        src_en = en; max_req = 1'b1;
        @(negedge clk);
        max_req = 1'b0;
    endtask

    function automatic logic [15:0] res(input int s);
        return result_flat[s*16 +: 16];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R9 index before any request
        for (int s = 0; s < NSRC; s++) check("R1 pending", res(s), 16'h8102);
        check("R1 max_word", max_word, 16'h8103);
        check("R9 max_src", max_src, 16'h8103);
        check("R1 offset", offset_view, 16'h0000);

        for (int i = 0; i < 12; i++) begin
            alt_fmt   = VEC[i][40];
            avg_shift = VEC[i][39:32];
            put_sample(VEC[i][43:41], VEC[i][31:16]);
            check($sformatf("R2/R3/R4 vec%0d", i), res(int'(VEC[i][43:41])), VEC[i][15:0]);
        end

        // R5/R6 offset in full format then integer format
        alt_fmt = 1'b0; avg_shift = 8'd0;
        write_off(16'h17C0);
        check("R6 view full", offset_view, 16'h17C0);
        check("R5 full add", res(1), 16'h0EC0);
        alt_fmt = 1'b1;
        @(negedge clk);
        check("R6 view alt", offset_view, 16'h005F);
        check("R5 alt add", res(1), 16'h003B);
        check("R2 code no offset", res(2), 16'h8000);
        write_off(16'h0005);
        check("R6 alt write", offset_view, 16'h0005);
        alt_fmt = 1'b0;
        @(negedge clk);
        check("R6 rescaled", offset_view, 16'h0140);
        write_off(16'h0000);

        // Stored: s0 FFCD, s1 F700, s2 8000 code, s3 1000, rest 8102
        ask_max(8'h0F);
        check("R7 max value", max_word, 16'h1000);
        check("R7 max index", max_src, 16'h0003);
        src_en = 8'h00;
        @(negedge clk);
        check("R7 hold without request", max_src, 16'h0003);
        ask_max(8'h07);
        check("R7 skip code value", max_word, 16'hFFCD);
        check("R7 skip code index", max_src, 16'h0000);
        put_sample(3'd4, 16'h1000);
        ask_max(8'h18);
        check("R7 tie value", max_word, 16'h1000);
        check("R7 tie lowest index", max_src, 16'h0003);
        alt_fmt = 1'b1;
        ask_max(8'h03);
        check("R7 integer max", max_word, 16'hFFFF);
        check("R7 integer index", max_src, 16'h0000);
        ask_max(8'h04);
        check("R8 only code word", max_word, 16'h8103);
        check("R8 only code index", max_src, 16'h8103);
        ask_max(8'h00);
        check("R8 none enabled", max_word, 16'h8103);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule